// File: doc/BRIEF.md
# Sampling Converter Serial Read Controller

This block sits on the host side of a three-wire serial sampling converter. It divides the system clock down to a free-running serial clock and issues a conversion-start strobe one serial-clock period wide. It shifts in the converter's data line and hands each finished sample to the core as a parallel word with a one-cycle valid pulse. A frame is measured in serial-clock rising edges. The short frame has 17 edges. The full-rate frame has 18, and the extra period gives the converter's track stage time to acquire.

A run input pauses or resumes free-running sampling. A power-down request input stops the serial clock, but only between frames. When the request is released, the clock restarts. A counter then measures the reference settling time in serial-clock rising edges, and every word delivered before that time has elapsed is marked as unsettled.

Top module: `adc_serial_reader`

## Requirements
- R1: When the interface is not powered down, `sck_o` is a square wave whose level changes every `CLK_DIV` system clocks.
- R2: `conv_o` rises only at the same clock edge at which `sck_o` falls, and it stays high for exactly one serial-clock period, that is, until the next `sck_o` fall.
- R3: Between two consecutive rising edges of `conv_o` there are never fewer than 17 rising edges of `sck_o`.
- R4: While `run_i` stays high and neither mode nor power-down changes, the gap between consecutive `conv_o` rising edges is exactly 17 `sck_o` rising edges with `full_rate_i` low, and exactly 18 with it high.
- R5: `sdo_i` is sampled only at the first 16 `sck_o` rising edges after a `conv_o` rise, most significant bit first. `data_o` carries the last `RES_BITS` of those 16 bits, and the leading `16-RES_BITS` bits are discarded.
- R6: `valid_o` is a single-cycle pulse. It rises at the clock edge where `sck_o` makes its 16th rise of a frame, and `data_o` changes at that same edge.
- R7: While `run_i` is low, no new `conv_o` pulse starts. A frame that is already running still completes and delivers its word.
- R8: When `sleep_i` is high at an `sck_o` fall where no frame is in progress, `sck_o` stays low and `conv_o` stays low until `sleep_i` drops.
- R9: After reset, and again after each power-down ends, `data_settled_o` is captured low with every word until `SETTLE_EDGES` `sck_o` rising edges have occurred. From then on it is captured high.
- R10: During reset `sck_o`, `conv_o`, `valid_o` and `data_settled_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Allows new conversion frames to start |
| sleep_i | input | 1 | Power-down request, honoured between frames |
| full_rate_i | input | 1 | 1: 18-edge frame, 0: 17-edge frame |
| sdo_i | input | 1 | Serial data from the converter |
| sck_o | output | 1 | Serial clock to the converter |
| conv_o | output | 1 | Conversion-start strobe |
| data_o | output | RES_BITS | Last captured sample |
| valid_o | output | 1 | One-cycle strobe, new sample on `data_o` |
| data_settled_o | output | 1 | Reference had settled when the sample was taken |

## Verification
A wrong edge count appears within one frame, either as a `conv_o` rise at the wrong `sck_o` fall or as `valid_o` firing at a rise other than the 16th. A shifter misalignment shows up on the first `valid_o` as a bit-shifted `data_o`. A stuck power-down state or a settle counter that fails to restart shows on `sck_o` at once, or on the settled flag of the first word after wake-up. The bench follows every output cycle by cycle against a behavioural model, so any of these faults is flagged in the cycle where it first appears.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int WINDOW_EDGES = 16;
  localparam int MIN_FRAME    = 17;
  localparam int EDGE_W       = 5;
  typedef logic [EDGE_W-1:0]       edge_cnt_t;
  typedef logic [WINDOW_EDGES-1:0] window_t;
  localparam edge_cnt_t EDGE_IDLE = '1;
endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  logic tick;
  logic sck_q;

  generate
    if (CLK_DIV == 1) begin : g_nodiv
      assign tick = !halt_i;
    end else begin : g_div
      localparam int DIV_W = $clog2(CLK_DIV);
      logic [DIV_W-1:0] div_q;
      assign tick = (div_q == DIV_W'(CLK_DIV-1)) && !halt_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               div_q <= '0;
        else if (halt_i || tick)   div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sck_q <= 1'b0;
    else if (tick) sck_q <= !sck_q;
  end

  assign sck_o  = sck_q;
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;

  AST_SCK_HALT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(sck_o)); // R8
  AST_SCK_RISE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> sck_o); // R1
endmodule

// File: rtl/adc_rd_settle.sv
module adc_rd_settle #(
  parameter int SETTLE_EDGES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic rise_i,
  output logic settled_o
);
  localparam int CNT_W = $clog2(SETTLE_EDGES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_EDGES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (wake_i)                  cnt_q <= '0;
    else if (rise_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q == LIMIT);

  AST_SETTLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !settled_o); // R9
endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                run_i,
  input  logic                hold_i,
  input  logic                full_rate_i,
  input  logic                sdo_i,
  input  logic                settled_i,
  output logic                conv_o,
  output logic                idle_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                data_ok_o
);
  edge_cnt_t edge_q;
  edge_cnt_t frame_len;
  window_t   shift_q;
  window_t   word;
  logic      start;
  logic      in_window;

  assign frame_len = full_rate_i ? edge_cnt_t'(MIN_FRAME + 1) : edge_cnt_t'(MIN_FRAME);
  assign idle_o    = (edge_q >= frame_len);
  assign start     = fall_i && idle_o && run_i && !hold_i;
  assign in_window = (edge_q < edge_cnt_t'(WINDOW_EDGES));
  assign word      = {shift_q[WINDOW_EDGES-2:0], sdo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_o    <= 1'b0;
      edge_q    <= EDGE_IDLE;
      shift_q   <= '0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      data_ok_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i) begin
        conv_o <= start;
        if (start) edge_q <= '0;
      end
      if (rise_i) begin
        if (edge_q != EDGE_IDLE) edge_q <= edge_q + 1'b1;
        if (in_window) shift_q <= word;
        if (edge_q == edge_cnt_t'(WINDOW_EDGES - 1)) begin
          valid_o   <= 1'b1;
          data_o    <= word[RES_BITS-1:0];
          data_ok_o <= settled_i;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_CONV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $past(edge_q) >= edge_cnt_t'(MIN_FRAME)); // R3
  AST_CONV_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && fall_i) |=> !conv_o); // R2
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int CLK_DIV      = 4,
  parameter int RES_BITS     = 14,
  parameter int SETTLE_EDGES = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                sleep_i,
  input  logic                full_rate_i,
  input  logic                sdo_i,
  output logic                sck_o,
  output logic                conv_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                data_settled_o
);
  logic rise, fall, idle, settled;
  logic asleep_q, wake;

  assign wake = asleep_q && !sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        asleep_q <= 1'b0;
    else if (wake)                      asleep_q <= 1'b0;
    else if (fall && sleep_i && idle)   asleep_q <= 1'b1;
  end

  adc_rd_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (asleep_q),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_rd_settle #(.SETTLE_EDGES(SETTLE_EDGES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wake_i    (wake),
    .rise_i    (rise),
    .settled_o (settled)
  );

  adc_rd_frame #(.RES_BITS(RES_BITS)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .run_i       (run_i),
    .hold_i      (sleep_i),
    .full_rate_i (full_rate_i),
    .sdo_i       (sdo_i),
    .settled_i   (settled),
    .conv_o      (conv_o),
    .idle_o      (idle),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .data_ok_o   (data_settled_o)
  );

  AST_CONV_ON_SCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $fell(sck_o)); // R2
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_q |-> (!sck_o && !conv_o)); // R8
endmodule

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
  localparam int DIV = 2;
  localparam int RES = 14;
  localparam int SET = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, sleep = 1'b0, full = 1'b0, sdo = 1'b0;
  logic sck, conv, valid, dok;
  logic [RES-1:0] data;

  always #5 clk = !clk;

  adc_serial_reader #(.CLK_DIV(DIV), .RES_BITS(RES), .SETTLE_EDGES(SET)) u_adc_serial_reader (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .sleep_i(sleep), .full_rate_i(full),
    .sdo_i(sdo), .sck_o(sck), .conv_o(conv), .data_o(data), .valid_o(valid),
    .data_settled_o(dok)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int m_div, m_edges, m_settle;
  bit m_sck, m_asleep, m_conv, m_valid, m_ok;
  logic [15:0] m_sh, m_word;
  logic [RES-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_sck = 0; m_asleep = 0; m_settle = 0; m_conv = 0;
      m_edges = 31; m_sh = 0; m_valid = 0; m_data = 0; m_ok = 0; m_word = 16'hACE1;
    end else begin
      bit tick, rs, fl, idle, wk;
      int len;
      tick = (m_div == DIV-1) && !m_asleep;
      rs = tick && !m_sck;
      fl = tick && m_sck;
      len = full ? 18 : 17;
      idle = m_edges >= len;
      wk = m_asleep && !sleep;
      m_div = (m_asleep || tick) ? 0 : m_div + 1;
      if (tick) m_sck = !m_sck;
      m_valid = 0;
      if (rs) begin
        if (m_edges < 16) m_sh = {m_sh[14:0], sdo};
        if (m_edges == 15) begin
          m_valid = 1; m_data = m_sh[RES-1:0]; m_ok = (m_settle == SET);
        end
        if (m_edges != 31) m_edges++;
      end
      if (fl) begin
        m_conv = idle && run && !sleep;
        if (m_conv) begin
          m_edges = 0;
          m_word = {m_word[14:0], m_word[15]^m_word[13]^m_word[12]^m_word[10]};
        end
      end
      if (wk) m_settle = 0;
      else if (rs && m_settle < SET) m_settle++;
      if (wk) m_asleep = 0;
      else if (fl && sleep && idle) m_asleep = 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive sdo and compare every cycle
  bit chk_exact = 0, have_prev = 0, prev_sck = 0, prev_conv = 0;
  int gap = 0, sck_rises = 0, conv_rises = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(sck == m_sck, "R1 sck", sck, m_sck);
      check(conv == m_conv, "R2 conv", conv, m_conv);
      check(valid == m_valid, "R6 valid", valid, m_valid);
      check(data == m_data, "R5 data", data, m_data);
      check(dok == m_ok, "R9 settled", dok, m_ok);
      if (valid) check(data == m_word[RES-1:0], "R5 sent word", data, m_word[RES-1:0]);
      if (sck && !prev_sck) begin gap++; sck_rises++; end
      if (conv && !prev_conv) begin
        conv_rises++;
        if (have_prev) begin
          check(gap >= 17, "R3 min gap", gap, 17);
          if (chk_exact) check(gap == (full ? 18 : 17), "R4 frame len", gap, full ? 18 : 17);
        end
        gap = 0; have_prev = 1;
      end
      prev_sck = sck; prev_conv = conv;
    end
    sdo = (m_edges < 16) ? m_word[15 - m_edges] : 1'b0;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int c0, s0;
    bit first_seen;
    repeat (5) @(negedge clk);
    check(!sck && !conv && !valid && !dok, "R10 reset state",
          {sck, conv, valid, dok}, 0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (200) @(negedge clk);
    chk_exact = 1;                      // R4 short frames
    repeat (700) @(negedge clk);
    chk_exact = 0; full = 1'b1;
    repeat (200) @(negedge clk);
    chk_exact = 1;                      // R4 full-rate frames
    repeat (800) @(negedge clk);
    chk_exact = 0; run = 1'b0;          // R7 pause
    repeat (100) @(negedge clk);
    c0 = conv_rises;
    repeat (300) @(negedge clk);
    check(conv_rises == c0, "R7 no conv while paused", conv_rises, c0);
    run = 1'b1; full = 1'b0;
    repeat (300) @(negedge clk);
    sleep = 1'b1;                       // R8 power-down
    repeat (200) @(negedge clk);
    s0 = sck_rises; c0 = conv_rises;
    repeat (300) @(negedge clk);
    check(sck_rises == s0, "R8 sck stopped", sck_rises, s0);
    check(conv_rises == c0, "R8 no conv asleep", conv_rises, c0);
    sleep = 1'b0;
    first_seen = 0;
    while (!first_seen) begin
      @(negedge clk);
      if (valid) begin
        first_seen = 1;
        check(dok == 1'b0, "R9 unsettled after wake", dok, 0);
      end
    end
    repeat (1200) @(negedge clk);
    check(dok == 1'b1, "R9 settled later", dok, 1);
    done = 1;
    summary();
  end
endmodule